// File: doc/BRIEF.md
# Power Gating Sequence Controller

This block takes one switchable logic domain through an ordered power-down and power-up handshake. A power-down request turns on the domain's isolation first and then turns off the power switch. A power-up request turns the switch back on first and then releases isolation. Each of the four steps waits for its own programmable number of clocks before it acts, so the gaps can be matched to how fast the switch network settles and how fast the isolation cells respond.

Software sets up the block through four small registers: an enable that allows power removal, the two power-up gaps, the two power-down gaps, and a status flag. The status flag reports whether the last power-down request actually removed power. Requests arrive as single-cycle pulses. A busy output is high while a sequence is running. Any request that arrives while busy, or that makes no sense for the current power state, has no effect.

Top module: `pwr_gate_ctrl`

## Requirements
- R1: After reset, pwr_sw_o is 1 (powered), iso_en_o is 0, busy_o is 0, and all four registers read 0.
- R2: The registers are addressed by reg_addr_i as follows: 0 is control (enable at bit 0), 1 is power-up gaps (switch gap S at bits 5:0, switch-to-isolation gap T at bits 13:8), 2 is power-down gaps (isolation gap N at bits 5:0, isolation-to-switch gap M at bits 13:8), and 3 is status (bit 0). Undefined bits read 0. The status register ignores writes.
- R3: When the domain is powered and idle and the enable is 0, a pdn_req_i pulse leaves pwr_sw_o at 1, iso_en_o at 0 and busy_o at 0, and clears status bit 0.
- R4: When the enable is 1, a pdn_req_i pulse that is accepted at clock edge k sets iso_en_o to 1 at edge k+1+N.
- R5: pwr_sw_o falls to 0 exactly 1+M clocks after iso_en_o rises.
- R6: A pup_req_i pulse accepted at edge j while the domain is powered down sets pwr_sw_o to 1 at edge j+1+S.
- R7: iso_en_o falls to 0 exactly 1+T clocks after pwr_sw_o rises during power-up.
- R8: Status bit 0 becomes 1 on the same clock edge at which pwr_sw_o falls for a power-down request.
- R9: busy_o is high from the clock after a request is accepted until the sequence ends. Requests made while busy are ignored. pup_req_i is ignored while the domain is powered, and pdn_req_i is ignored while it is powered down.
- R10: The enable is read only when a power-down request is accepted. Clearing it during a sequence does not stop that sequence.
- R11: pwr_sw_o is never 0 while iso_en_o is 0, and isolation is never released in the same clock as a switch change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_valid_i | input | 1 | Register access strobe |
| reg_write_i | input | 1 | Write when 1 with reg_valid_i |
| reg_addr_i | input | 2 | Register select |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data of the selected register |
| pdn_req_i | input | 1 | Power-down request pulse |
| pup_req_i | input | 1 | Power-up request pulse |
| iso_en_o | output | 1 | Domain isolation enable, 1 = isolated |
| pwr_sw_o | output | 1 | Power switch control, 1 = domain powered |
| busy_o | output | 1 | A sequence is in progress |

## Verification
The full down-and-up cycle is run with several sets of gaps. The sets include every gap at zero, every gap at its maximum of 63, and mixed small values in which one gap of a pair is zero and the other is not. Together these show whether the bench's count of 1+value clocks holds at each step and whether one gap is ever used in place of another. Directed cases then cover a request with the enable cleared, requests that arrive while busy or in the wrong power state, and clearing the enable during a sequence. In each case the bench compares the measured cycle positions and status against its own expected values.

// File: rtl/pwr_gate_pkg.sv
package pwr_gate_pkg;
  typedef enum logic [2:0] {
    ST_ON, ST_PD_ISO, ST_PD_SW, ST_OFF, ST_PU_SW, ST_PU_ISO
  } seq_state_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_PUP  = 2'd1;
  localparam logic [1:0] ADDR_PDN  = 2'd2;
  localparam logic [1:0] ADDR_STAT = 2'd3;
endpackage

// File: rtl/pwr_gate_regs.sv
module pwr_gate_regs #(
  parameter int unsigned DW     = 32,
  parameter int unsigned DLY_W  = 6,
  parameter int unsigned HI_LSB = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             write_i,
  input  logic [1:0]       addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  input  logic             stat_set_i,
  input  logic             stat_clr_i,
  output logic             pwr_en_o,
  output logic [DLY_W-1:0] sw_dly_o,
  output logic [DLY_W-1:0] sw2iso_dly_o,
  output logic [DLY_W-1:0] iso_dly_o,
  output logic [DLY_W-1:0] iso2sw_dly_o
);
  import pwr_gate_pkg::*;

  logic wr;
  logic stat_q;
  assign wr = valid_i && write_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwr_en_o     <= 1'b0;
      sw_dly_o     <= '0;
      sw2iso_dly_o <= '0;
      iso_dly_o    <= '0;
      iso2sw_dly_o <= '0;
    end else if (wr) begin
      unique case (addr_i)
        ADDR_CTRL: pwr_en_o <= wdata_i[0];
        ADDR_PUP: begin
          sw_dly_o     <= wdata_i[DLY_W-1:0];
          sw2iso_dly_o <= wdata_i[HI_LSB +: DLY_W];
        end
        ADDR_PDN: begin
          iso_dly_o    <= wdata_i[DLY_W-1:0];
          iso2sw_dly_o <= wdata_i[HI_LSB +: DLY_W];
        end
        default: ;
      endcase
    end
  end

  // status is read-only; set by completed power-down, cleared by refused one
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         stat_q <= 1'b0;
    else if (stat_set_i) stat_q <= 1'b1;
    else if (stat_clr_i) stat_q <= 1'b0;
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_CTRL: rdata_o[0] = pwr_en_o;
      ADDR_PUP: begin
        rdata_o[DLY_W-1:0]        = sw_dly_o;
        rdata_o[HI_LSB +: DLY_W]  = sw2iso_dly_o;
      end
      ADDR_PDN: begin
        rdata_o[DLY_W-1:0]        = iso_dly_o;
        rdata_o[HI_LSB +: DLY_W]  = iso2sw_dly_o;
      end
      default: rdata_o[0] = stat_q;
    endcase
  end
endmodule

// File: rtl/pwr_gate_seq.sv
module pwr_gate_seq #(
  parameter int unsigned DLY_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pdn_req_i,
  input  logic             pup_req_i,
  input  logic             pwr_en_i,
  input  logic [DLY_W-1:0] sw_dly_i,
  input  logic [DLY_W-1:0] sw2iso_dly_i,
  input  logic [DLY_W-1:0] iso_dly_i,
  input  logic [DLY_W-1:0] iso2sw_dly_i,
  output logic             iso_o,
  output logic             sw_o,
  output logic             busy_o,
  output logic             stat_set_o,
  output logic             stat_clr_o
);
  import pwr_gate_pkg::*;

  seq_state_e       state_q;
  logic [DLY_W-1:0] cnt_q;
  logic             cnt_done;

  assign cnt_done   = (cnt_q == '0);
  assign busy_o     = (state_q != ST_ON) && (state_q != ST_OFF);
  assign stat_set_o = (state_q == ST_PD_SW) && cnt_done;
  assign stat_clr_o = (state_q == ST_ON) && pdn_req_i && !pwr_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_ON;
      cnt_q   <= '0;
      iso_o   <= 1'b0;
      sw_o    <= 1'b1;
    end else begin
      unique case (state_q)
        ST_ON: if (pdn_req_i && pwr_en_i) begin
          // enable is consulted only here
          state_q <= ST_PD_ISO;
          cnt_q   <= iso_dly_i;
        end
        ST_PD_ISO:
          if (cnt_done) begin
            iso_o   <= 1'b1;
            state_q <= ST_PD_SW;
            cnt_q   <= iso2sw_dly_i;
          end else cnt_q <= cnt_q - 1'b1;
        ST_PD_SW:
          if (cnt_done) begin
            sw_o    <= 1'b0;
            state_q <= ST_OFF;
          end else cnt_q <= cnt_q - 1'b1;
        ST_OFF: if (pup_req_i) begin
          state_q <= ST_PU_SW;
          cnt_q   <= sw_dly_i;
        end
        ST_PU_SW:
          if (cnt_done) begin
            sw_o    <= 1'b1;
            state_q <= ST_PU_ISO;
            cnt_q   <= sw2iso_dly_i;
          end else cnt_q <= cnt_q - 1'b1;
        ST_PU_ISO:
          if (cnt_done) begin
            iso_o   <= 1'b0;
            state_q <= ST_ON;
          end else cnt_q <= cnt_q - 1'b1;
        default: state_q <= ST_ON;
      endcase
    end
  end
endmodule

// File: rtl/pwr_gate_ctrl.sv
module pwr_gate_ctrl #(
  parameter int unsigned DW     = 32,
  parameter int unsigned DLY_W  = 6,
  parameter int unsigned HI_LSB = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_valid_i,
  input  logic          reg_write_i,
  input  logic [1:0]    reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic          pdn_req_i,
  input  logic          pup_req_i,
  output logic          iso_en_o,
  output logic          pwr_sw_o,
  output logic          busy_o
);
  logic             pwr_en, stat_set, stat_clr;
  logic [DLY_W-1:0] sw_dly, sw2iso_dly, iso_dly, iso2sw_dly;

  pwr_gate_regs #(.DW(DW), .DLY_W(DLY_W), .HI_LSB(HI_LSB)) u_regs (
    .clk_i, .rst_ni,
    .valid_i(reg_valid_i), .write_i(reg_write_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .stat_set_i(stat_set), .stat_clr_i(stat_clr),
    .pwr_en_o(pwr_en), .sw_dly_o(sw_dly), .sw2iso_dly_o(sw2iso_dly),
    .iso_dly_o(iso_dly), .iso2sw_dly_o(iso2sw_dly)
  );

  pwr_gate_seq #(.DLY_W(DLY_W)) u_seq (
    .clk_i, .rst_ni,
    .pdn_req_i, .pup_req_i, .pwr_en_i(pwr_en),
    .sw_dly_i(sw_dly), .sw2iso_dly_i(sw2iso_dly),
    .iso_dly_i(iso_dly), .iso2sw_dly_i(iso2sw_dly),
    .iso_o(iso_en_o), .sw_o(pwr_sw_o), .busy_o(busy_o),
    .stat_set_o(stat_set), .stat_clr_o(stat_clr)
  );
endmodule

// File: rtl/pwr_gate_ctrl_chk.sv
module pwr_gate_ctrl_chk #(
  parameter int unsigned DW     = 32,
  parameter int unsigned DLY_W  = 6,
  parameter int unsigned HI_LSB = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          pdn_req_i,
  input logic          pup_req_i,
  input logic          iso_en_o,
  input logic          pwr_sw_o,
  input logic          busy_o,
  input logic          pwr_en,
  input logic [DW-1:0] reg_rdata_o
);
  localparam int unsigned TOP = HI_LSB + DLY_W;

  assert_iso_covers_off_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_sw_o |-> iso_en_o);

  assert_sw_off_after_iso_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pwr_sw_o) |-> $past(iso_en_o));

  assert_iso_release_after_sw_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(iso_en_o) |-> ($past(pwr_sw_o) && pwr_sw_o));

  assert_idle_on_clean_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && pwr_sw_o) |-> !iso_en_o);

  assert_disabled_ignored_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && pwr_sw_o && pdn_req_i && !pwr_en) |=> (!busy_o && pwr_sw_o));

  assert_busy_needs_req_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> ($past(pdn_req_i) || $past(pup_req_i)));

  assert_undef_bits_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o[DW-1:TOP] == '0) && (reg_rdata_o[HI_LSB-1:DLY_W] == '0));
endmodule

bind pwr_gate_ctrl pwr_gate_ctrl_chk #(.DW(DW), .DLY_W(DLY_W), .HI_LSB(HI_LSB)) u_chk (
  .clk_i, .rst_ni, .pdn_req_i, .pup_req_i, .iso_en_o, .pwr_sw_o, .busy_o,
  .pwr_en, .reg_rdata_o
);

// File: tb/pwr_gate_ctrl_tb.sv
module pwr_gate_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 5;
  // {iso gap N, iso-to-switch gap M, switch gap S, switch-to-iso gap T}
  localparam logic [23:0] VECS [NVEC] = '{
    {6'd0,  6'd0,  6'd0,  6'd0},
    {6'd3,  6'd5,  6'd2,  6'd7},
    {6'd63, 6'd63, 6'd63, 6'd63},
    {6'd1,  6'd0,  6'd0,  6'd1},
    {6'd10, 6'd2,  6'd4,  6'd0}
  };

  logic        clk = 0, rst_n = 0;
  logic        valid = 0, write = 0, pdn = 0, pup = 0;
  logic [1:0]  addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic        iso, sw, busy;
  int errors = 0, checks = 0;
  bit done = 0;

  pwr_gate_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_valid_i(valid), .reg_write_i(write),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .pdn_req_i(pdn), .pup_req_i(pup), .iso_en_o(iso), .pwr_sw_o(sw), .busy_o(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); valid = 1; write = 1; addr = a; wdata = d;
    @(negedge clk); valid = 0; write = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    valid = 1; write = 0; addr = a; #1; d = rdata; valid = 0;
  endtask

  // pulse request for one clock; returns at the negedge right after accept edge
  task automatic pulse(input bit down);
    @(negedge clk); if (down) pdn = 1; else pup = 1;
    @(negedge clk); pdn = 0; pup = 0;
  endtask

  // count negedges until output reaches level (which: 0 iso, 1 sw)
  task automatic wait_lvl(input bit which, input logic lvl, output int n);
    n = 0;
    while (((which ? sw : iso) !== lvl) && n < 300) begin
      @(negedge clk); n++;
    end
  endtask

  initial begin
    logic [31:0] d;
    int n;
    logic [5:0] vn, vm, vs, vt;
    #(CLK_PERIOD*3) rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 sw", sw, 1); check("R1 iso", iso, 0); check("R1 busy", busy, 0);
    for (int a = 0; a < 4; a++) begin rd(a[1:0], d); check("R1 reg", d, 0); end
    // R2 layout / undefined bits / status read-only
    for (int a = 0; a < 4; a++) wr(a[1:0], 32'hFFFF_FFFF);
    rd(2'd0, d); check("R2 ctrl", d, 32'h1);
    rd(2'd1, d); check("R2 pup", d, 32'h3F3F);
    rd(2'd2, d); check("R2 pdn", d, 32'h3F3F);
    rd(2'd3, d); check("R2 status", d, 0);
    wr(2'd1, 32'h0000_0205); rd(2'd1, d); check("R2 pup fields", d, 32'h205);

    // table walk: R4 R5 R6 R7 R8
    for (int i = 0; i < NVEC; i++) begin
      {vn, vm, vs, vt} = VECS[i];
      wr(2'd0, 32'h1);
      wr(2'd2, {18'd0, vm, 2'd0, vn});
      wr(2'd1, {18'd0, vt, 2'd0, vs});
      pulse(1);
      check("R9 busy after accept", busy, 1);
      wait_lvl(0, 1, n); check("R4 iso delay", n, vn + 1);
      check("R11 sw still on", sw, 1);
      wait_lvl(1, 0, n); check("R5 switch-off delay", n, vm + 1);
      rd(2'd3, d); check("R8 status", d, 1);
      check("R9 idle when off", busy, 0);
      pulse(0);
      wait_lvl(1, 1, n); check("R6 switch-on delay", n, vs + 1);
      check("R11 iso held", iso, 1);
      wait_lvl(0, 0, n); check("R7 iso release delay", n, vt + 1);
      check("R9 idle when on", busy, 0);
    end

    // R3 disabled request ignored and clears status
    wr(2'd0, 32'h0);
    pulse(1);
    check("R3 busy", busy, 0); check("R3 sw", sw, 1); check("R3 iso", iso, 0);
    repeat (3) @(negedge clk);
    check("R3 sw later", sw, 1);
    rd(2'd3, d); check("R3 status", d, 0);

    // R9 pup while on ignored
    pulse(0);
    check("R9 pup when on", busy, 0);
    check("R9 pup when on sw", sw, 1);

    // R9 requests while busy ignored, R10 enable cleared mid-sequence
    wr(2'd0, 32'h1);
    wr(2'd2, {18'd0, 6'd6, 2'd0, 6'd4});
    wr(2'd1, {18'd0, 6'd1, 2'd0, 6'd1});
    pulse(1);
    @(negedge clk); pup = 1; pdn = 1; @(negedge clk); pup = 0; pdn = 0;
    @(negedge clk); valid = 1; write = 1; addr = 2'd0; wdata = 0;
    @(negedge clk); valid = 0; write = 0;
    wait_lvl(0, 1, n); check("R9 iso timing unaffected", n, 1);
    wait_lvl(1, 0, n); check("R10 sequence completes", n, 7);
    rd(2'd3, d); check("R10 status", d, 1);
    // R9 pdn while off ignored
    pulse(1);
    check("R9 pdn when off busy", busy, 0);
    check("R9 pdn when off sw", sw, 0);
    pulse(0);
    wait_lvl(1, 1, n); check("R6 pup after ignored pdn", n, 2);
    wait_lvl(0, 0, n); check("R7 release", n, 2);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule